// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator

This block turns one shared duty command into two to four pulse-width modulated outputs, one for each power channel of a multiphase buck converter. All channels run at the same switching period. Their carriers are evenly spaced across that period, so the combined ripple at the output runs at the per-channel switching rate times the number of active channels. A larger duty command gives a longer on-time on every channel, and the output is never inverted relative to the command.

The number of active channels is fixed once, on the first clock after reset. At that point the block reads the level on the PWM pins, where unused channels are tied high. Each active channel's duty is then trimmed by a current-balance term. That term compares the channel's sampled current code with the average over the active channels only. A channel running hot gets a shorter pulse and a channel running cold gets a longer one. Each channel also emits a strobe telling the current-sense front end when to sample. The outputs can be released to high impedance on request.

The period, the per-channel phase offsets and the corrected duties are all captured together at a period boundary. A carrier therefore never sees a half-updated set of values.

Top module: `phase_pwm_gen`

## Requirements
- R1: On the first clock with `rstN` high the active count is taken from `pinSense` and held until the next reset. With MAX_CH=4: bits 3 and 2 both high give 2 channels; bit 3 high with bit 2 low gives 3 channels; any other pattern gives 4. Active channels are always the lowest-numbered ones.
- R2: Channel k (k = 0 to n-1) has phase offset floor(P*k/n), where P is the period and n the active count. With equal duties, channel k's rising edge comes that many clocks after channel 0's rising edge.
- R3: The master counter runs from 0 to P-1 and wraps. A new `periodCfg` value P is taken only at a period boundary, or on any clock while `enable` is low.
- R4: Within each period, a channel is high for exactly its corrected duty in clocks. With equal currents, that is `dutyCmd` clocks on every channel.
- R5: The corrected duty is `dutyCmd` - floor((cur_k - avg) / 2^GAIN_SHIFT). Here avg = floor(sum of the active channels' currents / n). The current code of channel k sits at `curSample[k*CUR_W +: CUR_W]`.
- R6: `sampleStb[k]` pulses for one clock when channel k's carrier equals (duty + floor(P/3)) mod P. This happens only when 0 < duty < P, giving one pulse per period.
- R7: While `triReq` is high, every `pwmOe` bit and every `pwmOut` bit is 0 from the next clock on. The master counter keeps running.
- R8: The corrected duty is clamped to the range [0, P].
- R9: Inactive channels never drive: their `pwmOe`, `pwmOut` and `sampleStb` bits stay 0. Their current codes are left out of the average.
- R10: While `enable` is low, active channels drive low with `pwmOe` high and give no strobe. The counter stays at 0.
- R11: While `rstN` is low, all outputs are 0. All outputs are registered: each output reflects the state of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the carriers; low holds active channels low |
| triReq | input | 1 | Release all outputs to high impedance |
| pinSense | input | MAX_CH | Level on the PWM pins, read once after reset |
| periodCfg | input | CNT_W | Switching period in clocks |
| dutyCmd | input | CNT_W | Shared on-time command in clocks |
| curSample | input | MAX_CH*CUR_W | Sampled current code per channel |
| pwmOut | output | MAX_CH | PWM level per channel |
| pwmOe | output | MAX_CH | Output enable per channel (0 = high impedance) |
| sampleStb | output | MAX_CH | Current-sample strobe per channel |

## Verification
The `triReq`, `enable` and reset effects show at the ports on the clock after they are applied. A change to `dutyCmd`, `periodCfg` or `curSample` takes effect only after the next period boundary, plus one register stage. The bench model applies the same two rules: it captures values only on its own boundary and issues outputs one clock late. Directed measurements of on-time, edge spacing and strobe count start only after two full periods have passed since the last change, so every sample falls in settled periods.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture period, offsets, duties, third
    logic run;    // carriers advancing
    logic drive;  // channel count known, outputs may drive
  } pwmStb_t;
endpackage

// File: rtl/phase_pwm_ctrl.sv
module phase_pwm_ctrl
  import phase_pwm_pkg::*;
#(
  parameter int MAX_CH = 4,
  parameter int CNT_W  = 10,
  parameter int NW     = $clog2(MAX_CH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [MAX_CH-1:0] pinSense,
  input  logic [CNT_W-1:0] periodCfg,
  output pwmStb_t          stb,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] perR,
  output logic [NW-1:0]    nAct
);
  logic            detDone;
  logic [CNT_W:0]  nextCnt;
  logic            wrapHit;
  logic            loadNow;

  // Count of active channels: unused channels are tied high from the top down
  function automatic logic [NW-1:0] decodeCount(input logic [MAX_CH-1:0] pins);
    logic [NW-1:0] n;
    logic          allHigh;
    n       = NW'(MAX_CH);
    allHigh = 1'b1;
    for (int i = MAX_CH - 1; i >= 2; i--) begin
      allHigh = allHigh & pins[i];
      if (allHigh) n = NW'(i);
    end
    return n;
  endfunction

  always_comb begin
    nextCnt   = {1'b0, cnt} + 1'b1;
    wrapHit   = nextCnt >= {1'b0, perR};
    loadNow   = detDone & (~enable | wrapHit);
    stb.load  = loadNow;
    stb.run   = detDone & enable;
    stb.drive = detDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detDone <= 1'b0;
      nAct    <= NW'(MAX_CH);
      cnt     <= '0;
      perR    <= '0;
    end else if (!detDone) begin
      detDone <= 1'b1;
      nAct    <= decodeCount(pinSense);
      cnt     <= '0;
    end else if (loadNow) begin
      perR <= periodCfg;
      cnt  <= '0;
    end else if (enable) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: counter stays inside the captured period
  a_r3_cnt_below_period: assert property (@(posedge clk) disable iff (!rstN)
    (detDone && perR != '0) |-> (cnt < perR));

  // R1: count is frozen once detected
  a_r1_count_held: assert property (@(posedge clk) disable iff (!rstN)
    detDone |=> $stable(nAct));

  // R1: count within the supported range
  a_r1_count_legal: assert property (@(posedge clk) disable iff (!rstN)
    detDone |-> (nAct >= NW'(2) && nAct <= NW'(MAX_CH)));

  // R10: counter parked while disabled
  a_r10_cnt_parked: assert property (@(posedge clk) disable iff (!rstN)
    (detDone && !enable) |=> (cnt == '0));
endmodule

// File: rtl/phase_pwm_dpath.sv
module phase_pwm_dpath
  import phase_pwm_pkg::*;
#(
  parameter int MAX_CH     = 4,
  parameter int CNT_W      = 10,
  parameter int CUR_W      = 8,
  parameter int GAIN_SHIFT = 1,
  parameter int NW         = $clog2(MAX_CH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pwmStb_t                 stb,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [CNT_W-1:0]        perR,
  input  logic [NW-1:0]           nAct,
  input  logic [CNT_W-1:0]        periodCfg,
  input  logic [CNT_W-1:0]        dutyCmd,
  input  logic [MAX_CH*CUR_W-1:0] curSample,
  input  logic                    triReq,
  output logic [MAX_CH-1:0]       pwmOut,
  output logic [MAX_CH-1:0]       pwmOe,
  output logic [MAX_CH-1:0]       sampleStb
);
  localparam int SUM_W = CUR_W + $clog2(MAX_CH + 1);
  localparam int PW    = CNT_W + $clog2(MAX_CH + 1);
  localparam int SW    = ((CNT_W > CUR_W) ? CNT_W : CUR_W) + 3;
  localparam int DW    = CUR_W + 2;

  logic [MAX_CH-1:0] activeMask;
  logic [SUM_W-1:0]  sumCur;
  logic [CUR_W-1:0]  avgCur;
  logic [CNT_W-1:0]  thirdNext;
  logic [CNT_W-1:0]  thirdR;

  // Average over active channels only
  always_comb begin
    sumCur = '0;
    for (int k = 0; k < MAX_CH; k++) begin
      if (activeMask[k]) sumCur = sumCur + SUM_W'(curSample[k*CUR_W +: CUR_W]);
    end
    avgCur    = CUR_W'(sumCur / SUM_W'(nAct));
    thirdNext = periodCfg / CNT_W'(3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         thirdR <= '0;
    else if (stb.load) thirdR <= thirdNext;
  end

  for (genvar k = 0; k < MAX_CH; k++) begin : g_ch
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] adj;
    logic signed [SW-1:0] rawDuty;
    logic signed [SW-1:0] perSigned;
    logic [CNT_W-1:0]     dutyNext;
    logic [PW-1:0]        offWide;
    logic [CNT_W-1:0]     offNext;
    logic [CNT_W-1:0]     offR;
    logic [CNT_W-1:0]     dutyR;
    logic [CNT_W-1:0]     car;
    logic [CNT_W:0]       posSum;
    logic [CNT_W:0]       pos;

    assign activeMask[k] = NW'(k) < nAct;

    // Current-balance trim and clamp
    always_comb begin
      diff      = $signed({2'b00, curSample[k*CUR_W +: CUR_W]}) - $signed({2'b00, avgCur});
      adj       = diff >>> GAIN_SHIFT;
      rawDuty   = $signed({{(SW-CNT_W){1'b0}}, dutyCmd}) - $signed({{(SW-DW){adj[DW-1]}}, adj});
      perSigned = $signed({{(SW-CNT_W){1'b0}}, periodCfg});
      if (rawDuty < 0)              dutyNext = '0;
      else if (rawDuty > perSigned) dutyNext = periodCfg;
      else                          dutyNext = rawDuty[CNT_W-1:0];
    end

    // Phase offset: period * k / n
    always_comb begin
      offWide = (PW'(periodCfg) * PW'(k)) / PW'(nAct);
      offNext = activeMask[k] ? offWide[CNT_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offR  <= '0;
        dutyR <= '0;
      end else if (stb.load) begin
        offR  <= offNext;
        dutyR <= dutyNext;
      end
    end

    // Shifted carrier and sample position
    always_comb begin
      car    = (cnt >= offR) ? (cnt - offR) : (cnt + perR - offR);
      posSum = {1'b0, dutyR} + {1'b0, thirdR};
      pos    = (posSum >= {1'b0, perR}) ? (posSum - {1'b0, perR}) : posSum;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pwmOut[k]    <= 1'b0;
        pwmOe[k]     <= 1'b0;
        sampleStb[k] <= 1'b0;
      end else if (!stb.drive || !activeMask[k] || triReq) begin
        pwmOut[k]    <= 1'b0;
        pwmOe[k]     <= 1'b0;
        sampleStb[k] <= 1'b0;
      end else if (!stb.run) begin
        pwmOut[k]    <= 1'b0;
        pwmOe[k]     <= 1'b1;
        sampleStb[k] <= 1'b0;
      end else begin
        pwmOut[k]    <= car < dutyR;
        pwmOe[k]     <= 1'b1;
        sampleStb[k] <= (dutyR != '0) && (dutyR < perR) && ({1'b0, car} == pos);
      end
    end

    // R8: captured duty never exceeds captured period
    a_r8_duty_within_period: assert property (@(posedge clk) disable iff (!rstN)
      dutyR <= perR);

    // R9: inactive channel never drives
    a_r9_inactive_no_drive: assert property (@(posedge clk) disable iff (!rstN)
      !activeMask[k] |=> (!pwmOe[k] && !sampleStb[k]));
  end

  // R7: high-impedance request removes all drive next clock
  a_r7_tri_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    triReq |=> (pwmOe == '0 && pwmOut == '0));

  // R10: disabled carriers hold outputs low
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |=> (pwmOut == '0));

  // R6: strobes only while carriers run
  a_r6_strobe_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |=> (sampleStb == '0));
endmodule

// File: rtl/phase_pwm_gen.sv
module phase_pwm_gen
  import phase_pwm_pkg::*;
#(
  parameter int MAX_CH     = 4,
  parameter int CNT_W      = 10,
  parameter int CUR_W      = 8,
  parameter int GAIN_SHIFT = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    triReq,
  input  logic [MAX_CH-1:0]       pinSense,
  input  logic [CNT_W-1:0]        periodCfg,
  input  logic [CNT_W-1:0]        dutyCmd,
  input  logic [MAX_CH*CUR_W-1:0] curSample,
  output logic [MAX_CH-1:0]       pwmOut,
  output logic [MAX_CH-1:0]       pwmOe,
  output logic [MAX_CH-1:0]       sampleStb
);
  localparam int NW = $clog2(MAX_CH + 1);

  pwmStb_t          stb;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] perR;
  logic [NW-1:0]    nAct;

  phase_pwm_ctrl #(.MAX_CH(MAX_CH), .CNT_W(CNT_W), .NW(NW)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .pinSense(pinSense),
    .periodCfg(periodCfg), .stb(stb), .cnt(cnt), .perR(perR), .nAct(nAct)
  );

  phase_pwm_dpath #(.MAX_CH(MAX_CH), .CNT_W(CNT_W), .CUR_W(CUR_W),
                    .GAIN_SHIFT(GAIN_SHIFT), .NW(NW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cnt(cnt), .perR(perR), .nAct(nAct),
    .periodCfg(periodCfg), .dutyCmd(dutyCmd), .curSample(curSample),
    .triReq(triReq), .pwmOut(pwmOut), .pwmOe(pwmOe), .sampleStb(sampleStb)
  );
endmodule

// File: tb/sim_phase_pwm_gen.sv
`timescale 1ns/1ps
module sim_phase_pwm_gen;
  localparam int MAX_CH = 4;
  localparam int CNT_W  = 10;
  localparam int CUR_W  = 8;
  localparam int GAIN   = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic triReq = 1'b0;
  logic [MAX_CH-1:0] pinSense = '0;
  logic [CNT_W-1:0] periodCfg = '0;
  logic [CNT_W-1:0] dutyCmd = '0;
  logic [MAX_CH*CUR_W-1:0] curSample = '0;
  logic [MAX_CH-1:0] pwmOut, pwmOe, sampleStb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R11";

  always #2 clk = ~clk;

  phase_pwm_gen #(.MAX_CH(MAX_CH), .CNT_W(CNT_W), .CUR_W(CUR_W), .GAIN_SHIFT(GAIN)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .triReq(triReq), .pinSense(pinSense),
    .periodCfg(periodCfg), .dutyCmd(dutyCmd), .curSample(curSample),
    .pwmOut(pwmOut), .pwmOe(pwmOe), .sampleStb(sampleStb)
  );

  // Behavioural reference model
  int mDet, mN, mCnt, mPer, mThird;
  int mOff[MAX_CH];
  int mDuty[MAX_CH];
  logic [MAX_CH-1:0] ePwm = '0, eOe = '0, eStb = '0;

  function automatic int curOf(int k);
    return int'(curSample[k*CUR_W +: CUR_W]);
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < MAX_CH; k++) begin
      if (!mDet || k >= mN || triReq) begin
        ePwm[k] = 0; eOe[k] = 0; eStb[k] = 0;
      end else if (!enable) begin
        ePwm[k] = 0; eOe[k] = 1; eStb[k] = 0;
      end else begin
        int car, pos;
        car = (mCnt >= mOff[k]) ? mCnt - mOff[k] : mCnt + mPer - mOff[k];
        pos = mDuty[k] + mThird;
        if (pos >= mPer) pos -= mPer;
        ePwm[k] = car < mDuty[k];
        eOe[k]  = 1;
        eStb[k] = (mDuty[k] > 0) && (mDuty[k] < mPer) && (car == pos);
      end
    end
    if (!rstN) begin
      mDet = 0; mN = MAX_CH; mCnt = 0; mPer = 0; mThird = 0;
      for (int k = 0; k < MAX_CH; k++) begin mOff[k] = 0; mDuty[k] = 0; end
      ePwm = '0; eOe = '0; eStb = '0;
    end else if (!mDet) begin
      mDet = 1; mCnt = 0;
      if (pinSense[3] && pinSense[2]) mN = 2;
      else if (pinSense[3]) mN = 3;
      else mN = 4;
    end else if (!enable || mCnt + 1 >= mPer) begin
      int sum, avg;
      sum = 0;
      for (int k = 0; k < mN; k++) sum += curOf(k);
      avg = sum / mN;
      mPer = int'(periodCfg);
      mThird = mPer / 3;
      for (int k = 0; k < MAX_CH; k++) begin
        int d;
        mOff[k] = (k < mN) ? (mPer * k) / mN : 0;
        d = int'(dutyCmd) - ((curOf(k) - avg) >>> GAIN);
        if (d < 0) d = 0;
        if (d > mPer) d = mPer;
        mDuty[k] = d;
      end
      mCnt = 0;
    end else begin
      mCnt++;
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (pwmOut !== ePwm || pwmOe !== eOe || sampleStb !== eStb) begin
        errors++;
        $display("FAIL %s cycle compare: pwm=%b oe=%b stb=%b expected pwm=%b oe=%b stb=%b",
                 tag, pwmOut, pwmOe, sampleStb, ePwm, eOe, eStb);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic [MAX_CH-1:0] pins);
    @(negedge clk);
    rstN = 0; enable = 0; triReq = 0; pinSense = pins;
    repeat (3) @(negedge clk);
    check("R11", int'({pwmOut, pwmOe, sampleStb}), 0, "outputs during reset");
    rstN = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic setCur(input int c0, input int c1, input int c2, input int c3);
    curSample = {CUR_W'(c3), CUR_W'(c2), CUR_W'(c1), CUR_W'(c0)};
  endtask

  task automatic onTime(input int ch, input int per, output int hi);
    hi = 0;
    repeat (per) begin
      @(negedge clk);
      if (pwmOut[ch]) hi++;
    end
  endtask

  task automatic strobeCount(input int ch, input int per, output int n);
    n = 0;
    repeat (per) begin
      @(negedge clk);
      if (sampleStb[ch]) n++;
    end
  endtask

  task automatic edgeGap(input int a, input int b, output int gap);
    logic pa, pb;
    int t, n;
    gap = -1;
    pa = pwmOut[a];
    t = 0;
    while (t < 400) begin
      @(negedge clk); t++;
      if (pwmOut[a] && !pa) break;
      pa = pwmOut[a];
    end
    pb = pwmOut[b];
    n = 0;
    while (n < 400) begin
      @(negedge clk); n++;
      if (pwmOut[b] && !pb) begin gap = n; break; end
      pb = pwmOut[b];
    end
  endtask

  initial begin
    int v;
    // Four channels (no pins tied high)
    tag = "R11";
    doReset(4'b0000);
    tag = "R10";
    periodCfg = 24; dutyCmd = 8; setCur(100, 100, 100, 100);
    repeat (5) @(negedge clk);
    check("R10", int'(pwmOe), 4'b1111, "oe while disabled, 4 channels");
    check("R10", int'(pwmOut), 0, "pwm while disabled");
    check("R1", int'(pwmOe), 4'b1111, "no pins high gives 4 channels");

    tag = "R4";
    enable = 1;
    repeat (48) @(negedge clk);
    onTime(0, 24, v); check("R4", v, 8, "ch0 on-time equal currents");
    onTime(2, 24, v); check("R4", v, 8, "ch2 on-time equal currents");
    tag = "R2";
    edgeGap(0, 1, v); check("R2", v, 6, "ch0 to ch1 offset, 4 channels");
    tag = "R6";
    strobeCount(1, 24, v); check("R6", v, 1, "one strobe per period");

    // Unbalanced currents: avg 100, duties 0,8,13,13
    tag = "R5";
    setCur(120, 100, 90, 90);
    repeat (48) @(negedge clk);
    onTime(2, 24, v); check("R5", v, 13, "cold channel lengthened");
    onTime(1, 24, v); check("R5", v, 8, "average channel unchanged");
    onTime(0, 24, v); check("R8", v, 0, "duty clamped at zero");
    strobeCount(0, 24, v); check("R6", v, 0, "no strobe at zero duty");

    // Upper clamp
    tag = "R8";
    dutyCmd = 24; setCur(0, 100, 100, 100);
    repeat (48) @(negedge clk);
    onTime(0, 24, v); check("R8", v, 24, "duty clamped at period");

    // Period change at boundary
    tag = "R3";
    dutyCmd = 10; setCur(50, 50, 50, 50);
    periodCfg = 30;
    repeat (60) @(negedge clk);
    onTime(3, 30, v); check("R3", v, 10, "on-time after period change");
    edgeGap(0, 3, v); check("R3", v, 22, "ch3 offset in new period");

    // High impedance
    tag = "R7";
    triReq = 1;
    repeat (2) @(negedge clk);
    check("R7", int'(pwmOe), 0, "oe released on request");
    repeat (10) @(negedge clk);
    check("R7", int'(pwmOut), 0, "pwm low while released");
    triReq = 0;
    repeat (40) @(negedge clk);

    // Three channels: pin 3 tied high
    tag = "R1";
    doReset(4'b1000);
    check("R1", int'(pwmOe), 4'b0111, "pin 3 high gives 3 channels");
    tag = "R9";
    periodCfg = 30; dutyCmd = 10; setCur(50, 80, 110, 200);
    enable = 1;
    repeat (60) @(negedge clk);
    onTime(1, 30, v); check("R9", v, 10, "ch3 current left out of average");
    onTime(0, 30, v); check("R5", v, 25, "hot-average trim, 3 channels");
    check("R9", int'(pwmOe[3]), 0, "inactive channel not driven");
    setCur(80, 80, 80, 200);
    repeat (60) @(negedge clk);
    edgeGap(0, 1, v); check("R2", v, 10, "ch0 to ch1 offset, 3 channels");

    // Pin 2 alone high: still four channels
    tag = "R1";
    doReset(4'b0100);
    check("R1", int'(pwmOe), 4'b1111, "pin 2 alone gives 4 channels");

    // Two channels
    doReset(4'b1100);
    check("R1", int'(pwmOe), 4'b0011, "pins 3 and 2 high give 2 channels");
    tag = "R2";
    periodCfg = 20; dutyCmd = 5; setCur(60, 60, 0, 0);
    enable = 1;
    repeat (40) @(negedge clk);
    edgeGap(0, 1, v); check("R2", v, 10, "ch0 to ch1 offset, 2 channels");
    tag = "R10";
    enable = 0;
    repeat (3) @(negedge clk);
    check("R10", int'(pwmOut), 0, "disable holds outputs low");
    check("R10", int'(pwmOe), 4'b0011, "disable keeps active drive");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule